// File: doc/BRIEF.md
# Hysteretic Gain-Ratio Regulation Controller

This block is the digital half of a bang-bang regulator for a step-down switched-capacitor converter. A hysteretic comparator outside the block reports whether the converter output has fallen below the lower edge of its band (bit high) or has climbed past the upper edge (bit low). The controller gates the power-stage clock on and off from that bit. It releases the load once regulation is first reached, and it selects one of three conversion gain ratios.

The block's clock runs at four times the power-stage switching rate, so each comparator decision is sampled four times per stage cycle. A one-cycle `stage_tick` marks each stage cycle. The converter starts at the lowest ratio with the stage running. If the stage is still running when seven stage cycles have passed, before the first switch-off, the ratio is stepped up. After the first switch-off, an on-period longer than four stage cycles also steps the ratio up, because the present ratio cannot carry the load. The ratio never steps down, and it returns to the lowest setting only on reset. An escalation request while already at the top ratio sets a sticky overload flag.

Top module: `hgr_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `gain_sel` is 2'b00, `stage_en` is 1, `load_en` is 0 and `overload` is 0.
- R2: The comparator bit passes through two synchronizer flops and one enable register. The value of `cmp_in` sampled at clock edge k appears on `stage_en` after edge k+2.
- R3: `load_en` rises on the same edge at which `stage_en` first falls after reset, and it stays high until reset.
- R4: Before the first switch-off, the gain ratio steps up by one level on the edge that samples the seventh `stage_tick` seen with `stage_en` high since reset or since the last ratio change.
- R5: After the first switch-off, the gain ratio steps up by one level on the edge that samples the fifth consecutive `stage_tick` seen with `stage_en` high.
- R6: `gain_sel` encodes 1/3 as 2'b00, 1/2 as 2'b01 and 2/3 as 2'b10. It only moves upward in that order, one level per step, and never takes 2'b11.
- R7: An escalation while `gain_sel` is 2'b10 leaves the ratio at 2'b10 and sets `overload`. Once set, `overload` stays high until reset.
- R8: The stage-cycle count restarts from zero whenever `stage_en` is low and whenever the ratio changes. On-periods separated by a switch-off therefore do not add up.
- R9: A `stage_tick` that arrives while `stage_en` is low has no effect on the gain ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the power-stage rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Hysteretic comparator bit, high = output below band |
| stage_tick | input | 1 | One-cycle pulse per power-stage cycle |
| stage_en | output | 1 | Power-stage clock enable |
| load_en | output | 1 | Load connect enable |
| gain_sel | output | 2 | Gain ratio select (00=1/3, 01=1/2, 10=2/3) |
| overload | output | 1 | Sticky flag: escalation requested at top ratio |

## Verification
The comparator is first held high from reset. This walks the ratio through every level on the start-up limit and then into overload, which separates the seven-cycle start-up rule from saturation. A second sequence alternates short on-periods of four cycles with switch-offs and then allows a fifth cycle. This separates the steady-state limit from the start-up limit and shows that the count clears on switch-off. Ticks delivered with the stage off show that an idle stage cannot escalate. A long stretch of randomly held comparator levels and irregular tick spacing is then compared cycle by cycle against a bench model of the requirements.

// File: rtl/hgr_pkg.sv
package hgr_pkg;

  typedef enum logic [1:0] {
    GR_THIRD    = 2'b00,
    GR_HALF     = 2'b01,
    GR_TWOTHIRD = 2'b10
  } gr_e;

  localparam int unsigned CNT_W = 4;

endpackage

// File: rtl/hgr_sync.sv
module hgr_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/hgr_gate.sv
module hgr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_sync,
  output logic stage_en,
  output logic load_en
);

  logic en_q, en_d;
  logic ld_q, ld_d;

  always_comb begin
    en_d = cmp_sync;
    ld_d = ld_q | (en_q & ~cmp_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
      ld_q <= 1'b0;
    end else begin
      en_q <= en_d;
      ld_q <= ld_d;
    end
  end

  assign stage_en = en_q;
  assign load_en  = ld_q;

  // R3: load release never withdrawn
  a_r3_load_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(ld_q));
  // R3: load release coincides with a stage switch-off
  a_r3_load_on_off: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_q) |-> $fell(en_q));

endmodule

// File: rtl/hgr_escal.sv
module hgr_escal
  import hgr_pkg::*;
#(
  parameter int unsigned START_LIMIT = 7,
  parameter int unsigned RUN_MAX_ON  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stage_en,
  input  logic       started,
  input  logic       tick,
  output logic [1:0] gain_sel,
  output logic       overload
);

  localparam int unsigned RUN_LIMIT = RUN_MAX_ON + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  gr_e              gr_q, gr_d;
  logic             ovl_q, ovl_d;
  logic             hit;
  logic [CNT_W-1:0] limit_m1;

  always_comb begin
    limit_m1 = started ? CNT_W'(RUN_LIMIT - 1) : CNT_W'(START_LIMIT - 1);
    hit      = stage_en & tick & (cnt_q == limit_m1);
    cnt_d    = cnt_q;
    gr_d     = gr_q;
    ovl_d    = ovl_q;
    if (!stage_en) begin
      cnt_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      case (gr_q)
        GR_THIRD: gr_d  = GR_HALF;
        GR_HALF:  gr_d  = GR_TWOTHIRD;
        default:  ovl_d = 1'b1;
      endcase
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      gr_q  <= GR_THIRD;
      ovl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      gr_q  <= gr_d;
      ovl_q <= ovl_d;
    end
  end

  assign gain_sel = gr_q;
  assign overload = ovl_q;

  // R6: ratio is monotonic and moves at most one level
  a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (gr_q >= $past(gr_q)) && (2'(gr_q - $past(gr_q)) <= 2'd1));
  a_r6_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
    gr_q != 2'b11);
  // R7: overload is sticky and only at the top ratio
  a_r7_ovl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovl_q) |-> ovl_q);
  a_r7_ovl_top: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_q |-> (gr_q == GR_TWOTHIRD));
  // R8: count empty after an off cycle
  a_r8_clear_off: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_en |=> (cnt_q == '0));
  // R9: an idle stage never escalates
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_en |=> $stable(gr_q));

endmodule

// File: rtl/hgr_ctrl.sv
module hgr_ctrl
  import hgr_pkg::*;
#(
  parameter int unsigned START_LIMIT = 7,
  parameter int unsigned RUN_MAX_ON  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_in,
  input  logic       stage_tick,
  output logic       stage_en,
  output logic       load_en,
  output logic [1:0] gain_sel,
  output logic       overload
);

  logic cmp_sync;

  hgr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (cmp_in),
    .d_out (cmp_sync)
  );

  hgr_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmp_sync (cmp_sync),
    .stage_en (stage_en),
    .load_en  (load_en)
  );

  hgr_escal #(.START_LIMIT(START_LIMIT), .RUN_MAX_ON(RUN_MAX_ON)) u_escal (
    .clk      (clk),
    .rst_n    (rst_n),
    .stage_en (stage_en),
    .started  (load_en),
    .tick     (stage_tick),
    .gain_sel (gain_sel),
    .overload (overload)
  );

  // R2: enable mirrors the synchronized comparator one edge later
  a_r2_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stage_en == $past(cmp_sync)));

endmodule

// File: tb/hgr_ctrl_tb.sv
module hgr_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b1;
  logic       stage_tick = 1'b0;
  logic       stage_en, load_en, overload;
  logic [1:0] gain_sel;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  hgr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .stage_tick(stage_tick),
    .stage_en(stage_en), .load_en(load_en), .gain_sel(gain_sel),
    .overload(overload)
  );

  // Reference model built from the requirements
  logic       m_s1, m_s2, m_en, m_ld, m_ovl;
  logic [1:0] m_gr;
  int         m_cnt;

  function automatic int lim(input logic started);
    return started ? 5 : 7;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_en <= 1'b1; m_ld <= 1'b0;
      m_gr <= 2'b00; m_ovl <= 1'b0; m_cnt <= 0;
    end else begin
      m_s1 <= cmp_in;
      m_s2 <= m_s1;
      m_en <= m_s2;
      if (m_en && !m_s2) m_ld <= 1'b1;
      if (!m_en) m_cnt <= 0;
      else if (stage_tick) begin
        if (m_cnt + 1 == lim(m_ld)) begin
          m_cnt <= 0;
          if (m_gr == 2'b10) m_ovl <= 1'b1;
          else m_gr <= m_gr + 2'd1;
        end else m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Continuous scoreboard at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 stage_en", stage_en, m_en);
      chk("R3 load_en", load_en, m_ld);
      chk("R4/R5/R6 gain_sel", gain_sel, m_gr);
      chk("R7 overload", overload, m_ovl);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick1();
    stage_tick = 1'b1; cyc(1); stage_tick = 1'b0; cyc(3);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick1();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmp_in = 1'b1; stage_tick = 1'b0;
    cyc(2);
    chk("R1 rst gain", gain_sel, 0);
    chk("R1 rst stage_en", stage_en, 1);
    chk("R1 rst load_en", load_en, 0);
    chk("R1 rst overload", overload, 0);
    rst_n = 1'b1; cyc(1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // Start-up escalation to saturation (R4, R6, R7)
    do_reset();
    ticks(6);
    chk("R4 six ticks no step", gain_sel, 0);
    tick1();
    chk("R4 seventh tick steps", gain_sel, 1);
    ticks(6);
    chk("R8 count restarted after step", gain_sel, 1);
    tick1();
    chk("R6 second step", gain_sel, 2);
    ticks(7);
    chk("R7 saturated", gain_sel, 2);
    chk("R7 overload set", overload, 1);
    cmp_in = 1'b0; cyc(3);
    chk("R2 off after latency", stage_en, 0);
    chk("R3 load on", load_en, 1);
    cmp_in = 1'b1; cyc(4);
    chk("R7 overload sticky", overload, 1);
    chk("R3 load stays", load_en, 1);

    // Steady-state limit and clearing (R5, R8, R9)
    do_reset();
    ticks(3);
    cmp_in = 1'b0; cyc(1);
    chk("R2 not yet off", stage_en, 1);
    cyc(2);
    chk("R2 off at third edge", stage_en, 0);
    chk("R3 load at first off", load_en, 1);
    cmp_in = 1'b1; cyc(4);
    ticks(4);
    chk("R5 four on-ticks no step", gain_sel, 0);
    cmp_in = 1'b0; cyc(4);
    cmp_in = 1'b1; cyc(4);
    ticks(4);
    chk("R8 off clears count", gain_sel, 0);
    tick1();
    chk("R5 fifth on-tick steps", gain_sel, 1);
    cmp_in = 1'b0; cyc(4);
    ticks(10);
    chk("R9 idle ticks ignored", gain_sel, 1);
    chk("R9 stage off", stage_en, 0);

    // Random held levels with irregular ticks
    begin
      int unsigned seed = 32'd1234;
      void'($urandom(seed));
      for (int r = 0; r < 4; r++) begin
        do_reset();
        for (int k = 0; k < 600; k++) begin
          int unsigned hold = $urandom_range(1, 24);
          cmp_in = ($urandom_range(0, 99) < 60);
          for (int h = 0; h < int'(hold); h++) begin
            stage_tick = ($urandom_range(0, 3) == 0);
            cyc(1);
          end
        end
        stage_tick = 1'b0;
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule